// File: doc/BRIEF.md
# Indirect Table Access Engine

This block gives software a way to reach three internal configuration tables through one small register port. The tables hold per-port binding entries, rule entries and classification-plan groups. Software never addresses these tables directly. It fills a staging window of eight 32-bit words, then writes a single action word. That word names the table, the entry or port, the direction and a word-select mask. The engine moves the selected words between the window and the chosen entry, one word per clock cycle, and then clears its busy flag.

A read loads the window with the entry's words. Software can then change one word and write the entry back with a second action. A malformed action is rejected: the engine raises an error flag and leaves every table untouched. While a transfer runs, the action word and the window are both locked against software writes.

Register port map: address 0 is the action word and addresses 1 to 8 are window words 0 to 7. Reads are combinational. Addresses above 8 read as zero and ignore writes.

Action word layout:

| Bits  | Meaning |
|-------|---------|
| 31    | busy / start |
| 30    | direction (1 = window to table) |
| 29    | error, read-only |
| 28:27 | table select |
| 26:24 | zero |
| 23:16 | entry number |
| 15:8  | word-select mask |
| 7:6   | zero |
| 5:0   | port number |

Top module: `itx_engine`

## Requirements
- R1: A write to address 0 with bit 31 set while idle starts a transfer. Bit 31 then reads 1 for exactly N cycles and 0 afterwards, where N is 2 for the port table (select 0), 4 for the rule table (select 1) and 8 for the plan table (select 2).
- R2: An action is rejected in any of these cases: select is 3; a port-table action has port >= 8; a rule action has entry >= 8; a plan action has entry >= 4. A rejected action keeps bit 31 high for 1 cycle, then reads with bit 29 set, and changes no table. An accepted action ends with bit 29 clear.
- R3: Bit 30 = 1 copies the window into the table. Bit 30 = 0 copies the table into the window.
- R4: For the port table, the entry is picked by the port field (bits 5:0). Mask bit 8 moves the 32-bit rule-membership word (window word 0). Mask bit 9 moves the binding word (window word 1). Words whose mask bit is clear do not move, in either direction.
- R5: The binding word keeps only its low 10 bits: group base in bits 4:0 and group mask in bits 9:5. Bits 31:10 read back as zero.
- R6: For the rule table, the entry is picked by bits 23:16 and has 4 words, with the packet counter in window word 3. When mask bit 8 is set, only the counter word moves; otherwise all 4 words move.
- R7: For the plan table, the group is picked by bits 23:16. Action bit 15-k selects plan entry k (window word k), and only selected entries move, in either direction.
- R8: After a full read, the window holds the whole entry. Changing one window word and writing the entry back alters only that word in the table.
- R9: While bit 31 reads 1, writes to the action word and to window words are ignored.
- R10: After reset the action word, all window words and all table contents read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 4 | Register address: 0 = action word, 1..8 = window words |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Combinational read data for cpu_addr |

## Verification
The action write is captured on one clock edge, and bit 31 reads 1 from that edge onward. The bench samples on falling edges and counts how many samples show bit 31 set. It compares that count with the length the requirements give: 2, 4 or 8 for accepted actions and 1 for a rejected one. The window and the error flag are compared only after bit 31 has dropped, since the last word moves on the edge that clears bit 31. Table contents are checked indirectly, by reading them back into the window with a later action and comparing against the bench's own model of all three tables.

// File: rtl/itx_pkg.sv
package itx_pkg;
  typedef enum logic [1:0] {
    TBL_PORT = 2'd0,
    TBL_RULE = 2'd1,
    TBL_PLAN = 2'd2,
    TBL_NONE = 2'd3
  } tbl_sel_e;

  localparam int ACT_W        = 32;
  localparam int ACT_GO       = 31;
  localparam int ACT_DIR      = 30;
  localparam int ACT_ERR      = 29;
  localparam int ENT_W        = 8;
  localparam int WS_W         = 8;
  localparam int PORT_W       = 6;
  localparam int PLAN_ENTRIES = 8;
  localparam int BIND_BITS    = 10;

  typedef struct packed {
    logic               dir;
    tbl_sel_e           sel;
    logic [ENT_W-1:0]   entry;
    logic [WS_W-1:0]    wsel;
    logic [PORT_W-1:0]  port;
  } act_fields_t;
endpackage

// File: rtl/itx_ctrl.sv
module itx_ctrl
  import itx_pkg::*;
#(
  parameter int NUM_PORTS  = 8,
  parameter int NUM_RULES  = 8,
  parameter int NUM_GROUPS = 4,
  parameter int RULE_WORDS = 4,
  parameter int WIDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_we,
  input  logic [ACT_W-1:0]  act_wdata,
  output logic [ACT_W-1:0]  act_word,
  output logic              busy,
  output tbl_sel_e          xfer_sel,
  output logic [ENT_W-1:0]  xfer_idx,
  output logic [WIDX_W-1:0] xfer_widx,
  output logic              xfer_dir,
  output logic              tbl_we,
  output logic              win_ld
);
  logic              go_q, go_d, err_q, err_d;
  act_fields_t       f_q, f_d;
  logic [WIDX_W-1:0] widx_q, widx_d, last_idx, plan_bit;
  logic              bad, wen;
  logic              unused_act_bits;

  assign unused_act_bits = ^{act_wdata[ACT_ERR], act_wdata[26:24], act_wdata[7:6]};

  // legality of the captured action
  always_comb begin
    unique case (f_q.sel)
      TBL_PORT: bad = (32'(f_q.port)  >= NUM_PORTS);
      TBL_RULE: bad = (32'(f_q.entry) >= NUM_RULES);
      TBL_PLAN: bad = (32'(f_q.entry) >= NUM_GROUPS);
      default:  bad = 1'b1;
    endcase
  end

  assign plan_bit = WIDX_W'(PLAN_ENTRIES - 1) - widx_q;

  // entry length and per-word enable
  always_comb begin
    unique case (f_q.sel)
      TBL_PORT: begin
        last_idx = WIDX_W'(1);
        wen      = f_q.wsel[widx_q];
      end
      TBL_RULE: begin
        last_idx = WIDX_W'(RULE_WORDS - 1);
        wen      = f_q.wsel[0] ? (widx_q == last_idx) : 1'b1;
      end
      TBL_PLAN: begin
        last_idx = WIDX_W'(PLAN_ENTRIES - 1);
        wen      = f_q.wsel[plan_bit];
      end
      default: begin
        last_idx = '0;
        wen      = 1'b0;
      end
    endcase
  end

  // next state
  always_comb begin
    go_d   = go_q;
    err_d  = err_q;
    f_d    = f_q;
    widx_d = widx_q;
    if (act_we && !go_q) begin
      f_d.dir   = act_wdata[ACT_DIR];
      f_d.sel   = tbl_sel_e'(act_wdata[28:27]);
      f_d.entry = act_wdata[23:16];
      f_d.wsel  = act_wdata[15:8];
      f_d.port  = act_wdata[5:0];
      err_d     = 1'b0;
      go_d      = act_wdata[ACT_GO];
      widx_d    = '0;
    end else if (go_q) begin
      if (bad) begin
        go_d  = 1'b0;
        err_d = 1'b1;
      end else if (widx_q == last_idx) begin
        go_d = 1'b0;
      end else begin
        widx_d = widx_q + WIDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      err_q  <= 1'b0;
      f_q    <= '0;
      widx_q <= '0;
    end else begin
      go_q   <= go_d;
      err_q  <= err_d;
      f_q    <= f_d;
      widx_q <= widx_d;
    end
  end

  assign act_word  = {go_q, f_q.dir, err_q, f_q.sel, 3'b000, f_q.entry, f_q.wsel, 2'b00, f_q.port};
  assign busy      = go_q;
  assign xfer_sel  = f_q.sel;
  assign xfer_idx  = (f_q.sel == TBL_PORT) ? ENT_W'(f_q.port) : f_q.entry;
  assign xfer_widx = widx_q;
  assign xfer_dir  = f_q.dir;
  assign tbl_we    = go_q && !bad && wen && f_q.dir;
  assign win_ld    = go_q && !bad && wen && !f_q.dir;
endmodule

// File: rtl/itx_window.sv
module itx_window #(
  parameter int DW        = 32,
  parameter int WIN_WORDS = 8,
  parameter int WIDX_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            busy,
  input  logic                            cpu_we,
  input  logic [WIDX_W-1:0]               cpu_idx,
  input  logic [DW-1:0]                   cpu_wdata,
  input  logic                            ld_en,
  input  logic [WIDX_W-1:0]               ld_idx,
  input  logic [DW-1:0]                   ld_data,
  output logic [WIN_WORDS-1:0][DW-1:0]    win
);
  logic [WIN_WORDS-1:0][DW-1:0] win_d;

  always_comb begin
    win_d = win;
    for (int g = 0; g < WIN_WORDS; g++) begin
      if (ld_en && (32'(ld_idx) == g))
        win_d[g] = ld_data;
      else if (cpu_we && !busy && (32'(cpu_idx) == g))
        win_d[g] = cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else        win <= win_d;
  end
endmodule

// File: rtl/itx_tables.sv
module itx_tables
  import itx_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NUM_PORTS  = 8,
  parameter int NUM_RULES  = 8,
  parameter int NUM_GROUPS = 4,
  parameter int RULE_WORDS = 4,
  parameter int WIDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tbl_sel_e          sel,
  input  logic [ENT_W-1:0]  idx,
  input  logic [WIDX_W-1:0] widx,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  logic [NUM_PORTS-1:0][DW-1:0]                      pmem_q, pmem_d;
  logic [NUM_PORTS-1:0][BIND_BITS-1:0]               pbind_q, pbind_d;
  logic [NUM_RULES-1:0][RULE_WORDS-1:0][DW-1:0]      rule_q, rule_d;
  logic [NUM_GROUPS-1:0][PLAN_ENTRIES-1:0][DW-1:0]   plan_q, plan_d;

  always_comb begin
    pmem_d  = pmem_q;
    pbind_d = pbind_q;
    rule_d  = rule_q;
    plan_d  = plan_q;
    if (we) begin
      unique case (sel)
        TBL_PORT:
          for (int e = 0; e < NUM_PORTS; e++)
            if (32'(idx) == e) begin
              if (widx == '0) pmem_d[e]  = wdata;
              else            pbind_d[e] = wdata[BIND_BITS-1:0];
            end
        TBL_RULE:
          for (int e = 0; e < NUM_RULES; e++)
            for (int w = 0; w < RULE_WORDS; w++)
              if ((32'(idx) == e) && (32'(widx) == w)) rule_d[e][w] = wdata;
        TBL_PLAN:
          for (int e = 0; e < NUM_GROUPS; e++)
            for (int w = 0; w < PLAN_ENTRIES; w++)
              if ((32'(idx) == e) && (32'(widx) == w)) plan_d[e][w] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmem_q  <= '0;
      pbind_q <= '0;
      rule_q  <= '0;
      plan_q  <= '0;
    end else begin
      pmem_q  <= pmem_d;
      pbind_q <= pbind_d;
      rule_q  <= rule_d;
      plan_q  <= plan_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      TBL_PORT:
        for (int e = 0; e < NUM_PORTS; e++)
          if (32'(idx) == e)
            rdata = (widx == '0) ? pmem_q[e] : DW'(pbind_q[e]);
      TBL_RULE:
        for (int e = 0; e < NUM_RULES; e++)
          for (int w = 0; w < RULE_WORDS; w++)
            if ((32'(idx) == e) && (32'(widx) == w)) rdata = rule_q[e][w];
      TBL_PLAN:
        for (int e = 0; e < NUM_GROUPS; e++)
          for (int w = 0; w < PLAN_ENTRIES; w++)
            if ((32'(idx) == e) && (32'(widx) == w)) rdata = plan_q[e][w];
      default: ;
    endcase
  end
endmodule

// File: rtl/itx_engine.sv
module itx_engine
  import itx_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NUM_PORTS  = 8,
  parameter int NUM_RULES  = 8,
  parameter int NUM_GROUPS = 4,
  parameter int RULE_WORDS = 4,
  localparam int WIN_WORDS = (RULE_WORDS > PLAN_ENTRIES) ? RULE_WORDS : PLAN_ENTRIES,
  localparam int WIDX_W    = $clog2(WIN_WORDS),
  localparam int ADDR_W    = $clog2(WIN_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata
);
  logic                          act_we, win_we, win_hit;
  logic [ACT_W-1:0]              act_word;
  logic                          busy, xfer_dir, tbl_we, win_ld;
  tbl_sel_e                      xfer_sel;
  logic [ENT_W-1:0]              xfer_idx;
  logic [WIDX_W-1:0]             xfer_widx, win_idx;
  logic [DW-1:0]                 tbl_rdata;
  logic [WIN_WORDS-1:0][DW-1:0]  win;

  assign act_we  = cpu_we && (cpu_addr == '0);
  assign win_hit = (cpu_addr != '0) && (32'(cpu_addr) <= WIN_WORDS);
  assign win_we  = cpu_we && win_hit;
  assign win_idx = WIDX_W'(cpu_addr - ADDR_W'(1));

  itx_ctrl #(
    .NUM_PORTS(NUM_PORTS), .NUM_RULES(NUM_RULES), .NUM_GROUPS(NUM_GROUPS),
    .RULE_WORDS(RULE_WORDS), .WIDX_W(WIDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .act_we(act_we), .act_wdata(cpu_wdata[ACT_W-1:0]), .act_word(act_word),
    .busy(busy), .xfer_sel(xfer_sel), .xfer_idx(xfer_idx), .xfer_widx(xfer_widx),
    .xfer_dir(xfer_dir), .tbl_we(tbl_we), .win_ld(win_ld)
  );

  itx_window #(.DW(DW), .WIN_WORDS(WIN_WORDS), .WIDX_W(WIDX_W)) u_win (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .cpu_we(win_we), .cpu_idx(win_idx), .cpu_wdata(cpu_wdata),
    .ld_en(win_ld), .ld_idx(xfer_widx), .ld_data(tbl_rdata),
    .win(win)
  );

  itx_tables #(
    .DW(DW), .NUM_PORTS(NUM_PORTS), .NUM_RULES(NUM_RULES), .NUM_GROUPS(NUM_GROUPS),
    .RULE_WORDS(RULE_WORDS), .WIDX_W(WIDX_W)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n), .sel(xfer_sel), .idx(xfer_idx), .widx(xfer_widx),
    .we(tbl_we), .wdata(win[xfer_widx]), .rdata(tbl_rdata)
  );

  always_comb begin
    if (cpu_addr == '0) cpu_rdata = DW'(act_word);
    else if (win_hit)   cpu_rdata = win[win_idx];
    else                cpu_rdata = '0;
  end
endmodule

// File: rtl/itx_engine_chk.sv
module itx_engine_chk #(
  parameter int DW        = 32,
  parameter int WIN_WORDS = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         act_we,
  input logic                         start_bit,
  input logic [31:0]                  act_word,
  input logic                         tbl_we,
  input logic                         xfer_dir,
  input logic [WIN_WORDS-1:0][DW-1:0] win
);
  logic       go, err;
  logic [7:0] busy_cnt;

  assign go  = act_word[31];
  assign err = act_word[29];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  busy_cnt <= '0;
    else if (go) busy_cnt <= busy_cnt + 8'd1;
    else         busy_cnt <= '0;
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_we && !go && start_bit) |=> go);

  p_bounded_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (32'(busy_cnt) < WIN_WORDS));

  p_err_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !go);

  p_no_err_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> !err);

  p_fields_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && act_we) |=> $stable(act_word[28:0]));

  p_window_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && xfer_dir) |=> $stable(win));
endmodule

bind itx_engine itx_engine_chk #(.DW(DW), .WIN_WORDS(WIN_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_we(act_we), .start_bit(cpu_wdata[31]),
  .act_word(act_word), .tbl_we(tbl_we), .xfer_dir(xfer_dir), .win(win)
);

// File: tb/itx_engine_test.sv
`timescale 1ns/1ps
module itx_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_we;
  logic [3:0]  cpu_addr;
  logic [31:0] cpu_wdata;
  logic [31:0] cpu_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_win   [8];
  logic [31:0] m_pmem  [8];
  logic [31:0] m_pbind [8];
  logic [31:0] m_rule  [8][4];
  logic [31:0] m_plan  [4][8];

  always #2.5 clk = ~clk;

  itx_engine uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [31:0] mk_act(input bit dir, input int sel, input int entry,
                                         input logic [7:0] ws, input int port);
    return {1'b1, dir, 1'b0, sel[1:0], 3'b000, entry[7:0], ws, 2'b00, port[5:0]};
  endfunction

  function automatic bit is_bad(input logic [31:0] a);
    int sel = int'(a[28:27]);
    if (sel == 3) return 1;
    if (sel == 0) return int'(a[5:0]) >= 8;
    if (sel == 1) return int'(a[23:16]) >= 8;
    return int'(a[23:16]) >= 4;
  endfunction

  function automatic int exp_len(input logic [31:0] a);
    if (is_bad(a)) return 1;
    case (int'(a[28:27]))
      0: return 2;
      1: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic string req_of(input logic [31:0] a);
    if (is_bad(a)) return "R2";
    case (int'(a[28:27]))
      0: return "R4";
      1: return "R6";
      default: return "R7";
    endcase
  endfunction

  // bench model of one accepted action
  function automatic void model_apply(input logic [31:0] a);
    bit dir = a[30];
    int sel = int'(a[28:27]);
    int ent = int'(a[23:16]);
    logic [7:0] ws = a[15:8];
    int prt = int'(a[5:0]);
    if (is_bad(a)) return;
    if (sel == 0) begin
      if (ws[0]) begin if (dir) m_pmem[prt] = m_win[0]; else m_win[0] = m_pmem[prt]; end
      if (ws[1]) begin if (dir) m_pbind[prt] = m_win[1] & 32'h3FF; else m_win[1] = m_pbind[prt]; end
    end else if (sel == 1) begin
      for (int w = 0; w < 4; w++)
        if (!ws[0] || w == 3) begin
          if (dir) m_rule[ent][w] = m_win[w]; else m_win[w] = m_rule[ent][w];
        end
    end else begin
      for (int k = 0; k < 8; k++)
        if (ws[7-k]) begin
          if (dir) m_plan[ent][k] = m_win[k]; else m_win[k] = m_plan[ent][k];
        end
    end
  endfunction

  task automatic cpu_wr(input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = addr; cpu_wdata = data;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [3:0] addr, output logic [31:0] data);
    cpu_addr = addr;
    #0.1;
    data = cpu_rdata;
  endtask

  task automatic win_set(input int w, input logic [31:0] d);
    cpu_wr(4'(w + 1), d);
    m_win[w] = d;
  endtask

  task automatic check_window(input string req);
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      cpu_rd(4'(w + 1), d);
      chk(d === m_win[w], req, d, m_win[w]);
    end
  endtask

  task automatic run_action(input logic [31:0] a);
    int cnt = 0;
    logic [31:0] d, exp;
    string req = req_of(a);
    cpu_wr(4'd0, a);
    cpu_addr = 4'd0;
    #0.1;
    while (cpu_rdata[31] && cnt < 40) begin
      cnt++;
      @(negedge clk);
      #0.1;
    end
    chk(cnt == exp_len(a), is_bad(a) ? "R2" : "R1", 32'(cnt), 32'(exp_len(a)));
    model_apply(a);
    exp = {1'b0, a[30], is_bad(a), a[28:0]};
    cpu_rd(4'd0, d);
    chk(d === exp, req, d, exp);
    check_window(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 00000000 expected 00000001");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a0;
    void'($urandom(32'h5EED_1234));
    cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; rst_n = 0;
    for (int i = 0; i < 8; i++) begin
      m_win[i] = 0; m_pmem[i] = 0; m_pbind[i] = 0;
      for (int w = 0; w < 4; w++) m_rule[i][w] = 0;
    end
    for (int g = 0; g < 4; g++) for (int k = 0; k < 8; k++) m_plan[g][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    cpu_rd(4'd0, d);
    chk(d === 32'h0, "R10", d, 32'h0);
    check_window("R10");
    run_action(mk_act(0, 1, 7, 8'h00, 0));  // R10 rule table reads zero

    // R3 write then read back through a cleared window
    win_set(0, 32'hA5A5_5A5A);
    run_action(mk_act(1, 0, 0, 8'h01, 2));
    win_set(0, 32'h0);
    run_action(mk_act(0, 0, 0, 8'h01, 2));
    cpu_rd(4'd1, d);
    chk(d === 32'hA5A5_5A5A, "R3", d, 32'hA5A5_5A5A);

    // R5 binding word keeps 10 bits
    win_set(1, 32'hFFFF_FFFF);
    run_action(mk_act(1, 0, 0, 8'h02, 3));
    win_set(1, 32'h0);
    run_action(mk_act(0, 0, 0, 8'h02, 3));
    cpu_rd(4'd2, d);
    chk(d === 32'h0000_03FF, "R5", d, 32'h3FF);

    // R7 mask bit 7 is plan entry 0
    for (int k = 0; k < 8; k++) win_set(k, 32'h7000_0000 + k);
    run_action(mk_act(1, 2, 1, 8'h80, 0));
    for (int k = 0; k < 8; k++) win_set(k, 32'h0);
    run_action(mk_act(0, 2, 1, 8'hFF, 0));
    cpu_rd(4'd1, d);
    chk(d === 32'h7000_0000, "R7", d, 32'h7000_0000);
    cpu_rd(4'd2, d);
    chk(d === 32'h0, "R7", d, 32'h0);

    // R6 counter-only update
    for (int w = 0; w < 4; w++) win_set(w, 32'h6000_0000 + w);
    run_action(mk_act(1, 1, 2, 8'h00, 0));
    for (int w = 0; w < 4; w++) win_set(w, 32'h6600_0000 + w);
    run_action(mk_act(1, 1, 2, 8'h01, 0));
    run_action(mk_act(0, 1, 2, 8'h00, 0));
    cpu_rd(4'd1, d);
    chk(d === 32'h6000_0000, "R6", d, 32'h6000_0000);
    cpu_rd(4'd4, d);
    chk(d === 32'h6600_0003, "R6", d, 32'h6600_0003);

    // R8 read-modify-write
    for (int w = 0; w < 4; w++) win_set(w, 32'h8000_0010 + w);
    run_action(mk_act(1, 1, 5, 8'h00, 9));
    for (int w = 0; w < 4; w++) win_set(w, 32'h0);
    run_action(mk_act(0, 1, 5, 8'h00, 9));
    win_set(2, 32'hBEEF_0002);
    run_action(mk_act(1, 1, 5, 8'h00, 9));
    for (int w = 0; w < 4; w++) win_set(w, 32'h0);
    run_action(mk_act(0, 1, 5, 8'h00, 9));
    cpu_rd(4'd3, d);
    chk(d === 32'hBEEF_0002, "R8", d, 32'hBEEF_0002);
    cpu_rd(4'd2, d);
    chk(d === 32'h8000_0011, "R8", d, 32'h8000_0011);

    // R2 directed rejects
    run_action(mk_act(1, 3, 0, 8'hFF, 0));
    run_action(mk_act(1, 2, 4, 8'hFF, 0));
    run_action(mk_act(1, 0, 0, 8'h03, 8));

    // R9 writes during a transfer are ignored
    for (int k = 0; k < 8; k++) win_set(k, 32'h9000_0000 + k);
    a0 = mk_act(1, 2, 0, 8'hFF, 1);
    cpu_wr(4'd0, a0);
    cpu_wr(4'd0, mk_act(0, 1, 3, 8'h01, 4));
    cpu_wr(4'd4, 32'hDEAD_DEAD);
    cpu_addr = 4'd0;
    #0.1;
    while (cpu_rdata[31]) begin @(negedge clk); #0.1; end
    model_apply(a0);
    cpu_rd(4'd0, d);
    chk(d === {1'b0, a0[30:0]}, "R9", d, {1'b0, a0[30:0]});
    check_window("R9");
    for (int k = 0; k < 8; k++) win_set(k, 32'h0);
    run_action(mk_act(0, 2, 0, 8'hFF, 0));
    cpu_rd(4'd4, d);
    chk(d === 32'h9000_0003, "R9", d, 32'h9000_0003);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r = int'($urandom % 16);
      int sel = (r == 15) ? 3 : r % 3;
      bit dir = 1'($urandom);
      if ($urandom % 2 == 0)
        for (int k = 0; k < 8; k++) win_set(k, $urandom);
      run_action(mk_act(dir, sel, int'($urandom % 10), 8'($urandom), int'($urandom % 10)));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule